// File: doc/BRIEF.md
# Parallel Port Buffer Direction Snooper

This block sits beside one or more 8255-style parallel port devices on a host bus. It works out which way each external bidirectional bus buffer must point. Software never programs the buffer direction itself. The block watches host writes to each device's command register. When a mode-set word arrives, the block takes the direction of port A, port B, the upper half of port C and the lower half of port C from that word. Each I/O group has its own command address and keeps its own copy of this state.

The block also drives one output enable per group for those buffers. A static mode strap selects how this enable behaves. In forced mode every buffer stays enabled. In controllable mode each group's enable follows one bit of a small host-writable tristate register. Direction tracking is the same in both modes.

The build can leave out the tristate register altogether. In that case the enables are tied on and the strap has no effect.

Top module: `ppi_buf_dir_ctrl`

## Requirements
- R1: While reset is applied and on the first cycle after it, every direction output is 1 (input). The tristate register is all zeros, so in controllable mode every buffer enable is 0.
- R2: A host write whose data has bit 7 set, to the command address of group g (GROUP_BASE + g*GROUP_STRIDE + CMD_OFS, default 3 for group 0 and 7 for group 1), updates group g's directions on the next cycle. grp_dir bit 4g+0 (port A) takes data bit 4. Bit 4g+1 (port B) takes data bit 1. Bit 4g+2 (port C upper) takes data bit 3. Bit 4g+3 (port C lower) takes data bit 0. A value of 1 means input.
- R3: A write to a command address whose data bit 7 is clear (a bit set/reset command) leaves that group's directions unchanged.
- R4: A write to any address other than group g's command address, including the other group's command address, a data port address or the tristate register address, leaves group g's directions unchanged.
- R5: Address and data presented while host_wr is low change no state.
- R6: When force_en is 1, every buf_en bit is 1, whatever the tristate register holds.
- R7: When force_en is 0, buf_en bit g equals tristate register bit g. A write to TRI_ADDR (default 0x0D) loads bit g from data bit g, and the new value shows on the next cycle.
- R8: Writes to the tristate register are stored while force_en is 1. After force_en returns to 0, buf_en shows the stored value.
- R9: Direction snooping works the same way when force_en is 1 as when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| force_en | input | 1 | Static mode strap: 1 keeps buffers always enabled, 0 hands control to the tristate register |
| grp_dir | output | 4*NUM_GROUPS | Per-port direction, 1 = input; bits 4g+0..3 are A, B, C upper, C lower |
| buf_en | output | NUM_GROUPS | Per-group buffer output enable |

## Verification
The hardest case to reach from the ports is a tristate register value written while the strap forces the enables on. That value cannot be seen until the strap is released, so the stimulus writes the register in forced mode, checks that the enables stay high, then drops the strap and reads the stored pattern. The snoop's selectivity is also hard to show. The stimulus first loads a non-default direction pattern into each group. It then sends bit set/reset commands, writes to the neighbouring group, writes to the data ports and writes to the tristate register, and drives bus cycles without the strobe. The outputs must stay put through all of these.

// File: rtl/ppi_snoop_pkg.sv
package ppi_snoop_pkg;

   localparam int unsigned PPI_DATA_W  = 8;
   // bit positions inside a mode-set command word
   localparam int unsigned MS_FLAG_BIT = 7;
   localparam int unsigned MS_A_BIT    = 4;
   localparam int unsigned MS_CU_BIT   = 3;
   localparam int unsigned MS_B_BIT    = 1;
   localparam int unsigned MS_CL_BIT   = 0;

   // packed so that port A lands on bit 0
   typedef struct packed {
      logic cl;
      logic cu;
      logic b;
      logic a;
   } port_dir_t;

   localparam port_dir_t DIR_ALL_INPUT = port_dir_t'(4'hF);

   function automatic logic is_mode_set(input logic [PPI_DATA_W-1:0] cmd);
      return cmd[MS_FLAG_BIT];
   endfunction

   function automatic port_dir_t mode_word_to_dir(input logic [PPI_DATA_W-1:0] cmd);
      port_dir_t d;
      d.a  = cmd[MS_A_BIT];
      d.b  = cmd[MS_B_BIT];
      d.cu = cmd[MS_CU_BIT];
      d.cl = cmd[MS_CL_BIT];
      return d;
   endfunction

endpackage

// File: rtl/ppi_cmd_decode.sv
module ppi_cmd_decode
   import ppi_snoop_pkg::*;
#(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned NUM_GROUPS   = 2,
   parameter int unsigned GROUP_BASE   = 0,
   parameter int unsigned GROUP_STRIDE = 4,
   parameter int unsigned CMD_OFS      = 3
) (
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [PPI_DATA_W-1:0] host_wdata,
   input  logic                  host_wr,
   output logic [NUM_GROUPS-1:0] load_grp,
   output port_dir_t             load_dir
);

   logic mode_set;
   logic unused_cmd_bits;

   assign mode_set        = is_mode_set(host_wdata);
   assign load_dir        = mode_word_to_dir(host_wdata);
   assign unused_cmd_bits = ^{host_wdata[6:5], host_wdata[2]};

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_match
      localparam int unsigned CMD_ADDR = GROUP_BASE + g * GROUP_STRIDE + CMD_OFS;
      localparam logic [ADDR_W-1:0] CMD_ADDR_V = CMD_ADDR[ADDR_W-1:0];
      assign load_grp[g] = host_wr && mode_set && (host_addr == CMD_ADDR_V);
   end

endmodule

// File: rtl/ppi_dir_track.sv
module ppi_dir_track
   import ppi_snoop_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  port_dir_t load_dir,
   output port_dir_t dir
);

   port_dir_t dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_ALL_INPUT;
      end else if (load) begin
         dir_q <= load_dir;
      end
   end

   assign dir = dir_q;

endmodule

// File: rtl/ppi_buf_enable.sv
module ppi_buf_enable
   import ppi_snoop_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned NUM_GROUPS = 2,
   parameter int unsigned TRI_ADDR   = 13,
   parameter bit          OE_CTRL_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [PPI_DATA_W-1:0] host_wdata,
   input  logic                  host_wr,
   input  logic                  force_en,
   output logic [NUM_GROUPS-1:0] buf_en
);

   localparam logic [ADDR_W-1:0] TRI_ADDR_V = TRI_ADDR[ADDR_W-1:0];

   if (OE_CTRL_EN) begin : g_reg_ctrl
      logic [NUM_GROUPS-1:0] tri_q;
      logic                  tri_wr;
      logic                  unused_wdata;

      assign tri_wr       = host_wr && (host_addr == TRI_ADDR_V);
      assign unused_wdata = ^host_wdata;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tri_q <= '0;
         end else if (tri_wr) begin
            tri_q <= host_wdata[NUM_GROUPS-1:0];
         end
      end

      assign buf_en = force_en ? '1 : tri_q;
   end else begin : g_fixed_on
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, host_addr, host_wdata, host_wr, force_en};
      assign buf_en        = '1;
   end

endmodule

// File: rtl/ppi_buf_dir_ctrl.sv
module ppi_buf_dir_ctrl
   import ppi_snoop_pkg::*;
#(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned NUM_GROUPS   = 2,
   parameter int unsigned GROUP_BASE   = 0,
   parameter int unsigned GROUP_STRIDE = 4,
   parameter int unsigned CMD_OFS      = 3,
   parameter int unsigned TRI_ADDR     = 13,
   parameter bit          OE_CTRL_EN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       host_addr,
   input  logic [7:0]              host_wdata,
   input  logic                    host_wr,
   input  logic                    force_en,
   output logic [4*NUM_GROUPS-1:0] grp_dir,
   output logic [NUM_GROUPS-1:0]   buf_en
);

   localparam int unsigned SPAN_END = GROUP_BASE + NUM_GROUPS * GROUP_STRIDE;
   localparam bit TRI_IN_SPAN = (TRI_ADDR >= GROUP_BASE) && (TRI_ADDR < SPAN_END);
   localparam bit TRI_ON_CMD  = TRI_IN_SPAN &&
                                (((TRI_ADDR - GROUP_BASE) % GROUP_STRIDE) == CMD_OFS);

   if (NUM_GROUPS < 1 || NUM_GROUPS > PPI_DATA_W) begin : g_chk_groups
      $error("NUM_GROUPS must be between 1 and the data width");
   end
   if (CMD_OFS >= GROUP_STRIDE) begin : g_chk_ofs
      $error("CMD_OFS must fall inside one group stride");
   end
   if (SPAN_END > (1 << ADDR_W) || TRI_ADDR >= (1 << ADDR_W)) begin : g_chk_span
      $error("decoded addresses do not fit in ADDR_W");
   end
   if (TRI_ON_CMD) begin : g_chk_tri
      $error("TRI_ADDR collides with a command address");
   end

   logic [NUM_GROUPS-1:0] load_grp;
   port_dir_t             load_dir;

   ppi_cmd_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_GROUPS  (NUM_GROUPS),
      .GROUP_BASE  (GROUP_BASE),
      .GROUP_STRIDE(GROUP_STRIDE),
      .CMD_OFS     (CMD_OFS)
   ) u_decode (
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_wr   (host_wr),
      .load_grp  (load_grp),
      .load_dir  (load_dir)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      port_dir_t dir_g;

      ppi_dir_track u_track (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load_grp[g]),
         .load_dir(load_dir),
         .dir     (dir_g)
      );

      assign grp_dir[4*g +: 4] = dir_g;
   end

   ppi_buf_enable #(
      .ADDR_W    (ADDR_W),
      .NUM_GROUPS(NUM_GROUPS),
      .TRI_ADDR  (TRI_ADDR),
      .OE_CTRL_EN(OE_CTRL_EN)
   ) u_oe (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_wr   (host_wr),
      .force_en  (force_en),
      .buf_en    (buf_en)
   );

endmodule

// File: rtl/ppi_buf_dir_ctrl_chk.sv
module ppi_buf_dir_ctrl_chk #(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned NUM_GROUPS   = 2,
   parameter int unsigned GROUP_BASE   = 0,
   parameter int unsigned GROUP_STRIDE = 4,
   parameter int unsigned CMD_OFS      = 3,
   parameter int unsigned TRI_ADDR     = 13,
   parameter bit          OE_CTRL_EN   = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       host_addr,
   input logic [7:0]              host_wdata,
   input logic                    host_wr,
   input logic                    force_en,
   input logic [4*NUM_GROUPS-1:0] grp_dir,
   input logic [NUM_GROUPS-1:0]   buf_en
);

   localparam logic [ADDR_W-1:0] TRI_A = TRI_ADDR[ADDR_W-1:0];

   // R1
   reset_dir_chk: assert property (@(posedge clk) $rose(rst_n) |-> grp_dir == '1);

   // R6
   forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_en |-> buf_en == '1);

   // R5
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable(grp_dir));

   if (OE_CTRL_EN) begin : g_oe
      // R1
      reset_oe_chk: assert property (@(posedge clk)
         ($rose(rst_n) && !force_en) |-> buf_en == '0);

      // R7
      tri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_addr == TRI_A && !force_en) ##1 !force_en
         |-> buf_en == $past(host_wdata[NUM_GROUPS-1:0]));
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int unsigned CA = GROUP_BASE + g * GROUP_STRIDE + CMD_OFS;
      localparam logic [ADDR_W-1:0] CMD_A = CA[ADDR_W-1:0];

      // R2
      mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_addr == CMD_A && host_wdata[7]) |=>
         grp_dir[4*g +: 4] == {$past(host_wdata[0]), $past(host_wdata[3]),
                               $past(host_wdata[1]), $past(host_wdata[4])});

      // R3
      bsr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_addr == CMD_A && !host_wdata[7]) |=>
         $stable(grp_dir[4*g +: 4]));

      // R4
      other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_addr != CMD_A) |=> $stable(grp_dir[4*g +: 4]));
   end

endmodule

bind ppi_buf_dir_ctrl ppi_buf_dir_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .NUM_GROUPS  (NUM_GROUPS),
   .GROUP_BASE  (GROUP_BASE),
   .GROUP_STRIDE(GROUP_STRIDE),
   .CMD_OFS     (CMD_OFS),
   .TRI_ADDR    (TRI_ADDR),
   .OE_CTRL_EN  (OE_CTRL_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_addr (host_addr),
   .host_wdata(host_wdata),
   .host_wr   (host_wr),
   .force_en  (force_en),
   .grp_dir   (grp_dir),
   .buf_en    (buf_en)
);

// File: tb/ppi_buf_dir_ctrl_tb.sv
module ppi_buf_dir_ctrl_tb;

   localparam int AW   = 5;
   localparam int NG   = 2;
   localparam logic [AW-1:0] CMD0 = 5'd3;
   localparam logic [AW-1:0] CMD1 = 5'd7;
   localparam logic [AW-1:0] TRIA = 5'd13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0]    host_wdata = '0;
   logic          host_wr = 1'b0;
   logic          force_en = 1'b0;
   logic [4*NG-1:0] grp_dir;
   logic [NG-1:0]   buf_en;

   int checks = 0;
   int failures = 0;
   logic [3:0] exp_d [NG];

   always #2 clk = ~clk;

   ppi_buf_dir_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .force_en(force_en), .grp_dir(grp_dir), .buf_en(buf_en)
   );

   function automatic logic [3:0] dir_of(input logic [7:0] w);
      return {w[0], w[3], w[1], w[4]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_dirs(input string req);
      check(req, 32'(grp_dir), 32'({exp_d[1], exp_d[0]}));
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 dir", 32'(grp_dir), 32'hFF);
      check("R1 oe", 32'(buf_en), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      check("R1 dir after release", 32'(grp_dir), 32'hFF);
      exp_d[0] = 4'hF; exp_d[1] = 4'hF;
   endtask

   task automatic t_mode_set();
      bus_write(CMD0, 8'h80); exp_d[0] = 4'h0;
      check_dirs("R2 all out g0, R4 g1 held");
      bus_write(CMD0, 8'h90); exp_d[0] = dir_of(8'h90);
      check("R2 port A bit", 32'(grp_dir[3:0]), 32'h1);
      bus_write(CMD0, 8'h8A); exp_d[0] = dir_of(8'h8A);
      check("R2 B and C upper", 32'(grp_dir[3:0]), 32'h6);
      bus_write(CMD1, 8'h81); exp_d[1] = dir_of(8'h81);
      check_dirs("R2 C lower g1, R4 g0 held");
   endtask

   task automatic t_ignored();
      bus_write(CMD0, 8'h0F);
      check_dirs("R3 bit set/reset g0");
      bus_write(CMD1, 8'h7E);
      check_dirs("R3 bit set/reset g1");
      for (int a = 0; a < 3; a++) begin
         bus_write(AW'(a), 8'h80);
         check_dirs("R4 data port address");
      end
      bus_write(TRIA, 8'h80);
      check_dirs("R4 tristate address");
      bus_write(5'd11, 8'h80);
      check_dirs("R4 outside span");
      @(negedge clk);
      host_addr = CMD0; host_wdata = 8'h80; host_wr = 1'b0;
      @(negedge clk);
      check_dirs("R5 no strobe");
      bus_write(TRIA, 8'h00);
   endtask

   task automatic t_tristate();
      force_en = 1'b0;
      bus_write(TRIA, 8'h01);
      check("R7 g0 only", 32'(buf_en), 32'h1);
      bus_write(TRIA, 8'h02);
      check("R7 g1 only", 32'(buf_en), 32'h2);
      @(negedge clk);
      host_addr = TRIA; host_wdata = 8'h03; host_wr = 1'b0;
      @(negedge clk);
      check("R5 tristate no strobe", 32'(buf_en), 32'h2);
      bus_write(TRIA, 8'hFF);
      check("R7 both", 32'(buf_en), 32'h3);
   endtask

   task automatic t_forced();
      bus_write(TRIA, 8'h00);
      force_en = 1'b1;
      @(negedge clk);
      check("R6 forced on", 32'(buf_en), 32'h3);
      bus_write(TRIA, 8'h02);
      check("R6 forced after write", 32'(buf_en), 32'h3);
      bus_write(CMD1, 8'h98); exp_d[1] = dir_of(8'h98);
      check_dirs("R9 snoop in forced mode");
      force_en = 1'b0;
      @(negedge clk);
      check("R8 stored value", 32'(buf_en), 32'h2);
   endtask

   initial begin
      #(4 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_mode_set();
      t_ignored();
      t_tristate();
      t_forced();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule